// File: doc/BRIEF.md
# Five-Stage Pipeline Hazard Unit

This block is the combinational hazard logic that sits beside an in-order pipeline with five stages: fetch, register read/decode, execute, memory and writeback. Each cycle it reads the register fields and flags of the instructions in decode, execute, memory and writeback. From these it sets the bypass multiplexers for the execute operands and for the decode operands. It also decides whether fetch and decode must hold while a no-operation enters execute, and it chooses the next fetch address.

Branches are resolved in decode. A taken branch redirects fetch on the following edge. The single instruction fetched behind a branch is its delay slot, and the unit never discards it. Until a branch resolves, fetch keeps going along the sequential path. A loaded value exists only after the memory stage. Because of this, a consumer that directly follows a load costs one bubble. A branch whose operand is still being computed waits until that operand can reach decode through a bypass.

Top module: `hazard_unit`

## Requirements
- R1: The execute operand select (`fwd_a_sel` for `ex_rs1`, `fwd_b_sel` for `ex_rs2`) is 1 (memory-stage result) when the memory-stage instruction writes a nonzero register equal to that source. This holds even when writeback also matches.
- R2: The execute operand select is 2 (writeback result) when only the writeback instruction writes the matching nonzero register. It is 0 (register file) when neither stage writes it with its write enable set.
- R3: Register 0 as a source never selects a bypass and never raises `stall`, whatever the other stages write.
- R4: When execute holds a load (`ex_is_load`, `ex_wen`) whose nonzero destination equals a decode source, `stall` and `bubble` are 1, `npc_sel` is 2 (hold) and `next_pc` equals `fetch_pc`.
- R5: A load in the memory stage that matches a source of a non-branch in decode raises no stall. The independent instruction between them already supplies the gap.
- R6: The decode operand select (`dec_a_sel`, `dec_b_sel`) is 1 for a matching non-load memory-stage result. Otherwise it is 2 for a matching writeback write, which is the same-cycle write bypass. Otherwise it is 0. Memory takes priority over writeback.
- R7: A branch in decode whose nonzero source matches the destination of any writing instruction in execute raises `stall`. A non-branch in the same situation does not stall unless execute holds a load.
- R8: A branch in decode whose source matches a load in the memory stage stalls. If the memory-stage producer is an ALU result instead, there is no stall and the decode select is 1.
- R9: A not-taken branch with no stall gives `npc_sel` 0 and `next_pc` = `fetch_pc` + 4.
- R10: A taken branch with no stall gives `npc_sel` 1, `next_pc` = `dec_br_target`, and `stall` 0. The delay slot behind the branch is kept.
- R11: `dec_br_taken` is ignored unless `dec_is_branch` is 1. A non-branch gives `npc_sel` 0 and `next_pc` = `fetch_pc` + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fetch_pc | input | PC_W | Address of the instruction now being fetched |
| dec_rs1 | input | RA_W | First source register of the decode-stage instruction |
| dec_rs2 | input | RA_W | Second source register of the decode-stage instruction |
| dec_is_branch | input | 1 | Decode-stage instruction is a branch or jump |
| dec_br_taken | input | 1 | Branch outcome evaluated in decode |
| dec_br_target | input | PC_W | Branch destination evaluated in decode |
| ex_rs1 | input | RA_W | First source register of the execute-stage instruction |
| ex_rs2 | input | RA_W | Second source register of the execute-stage instruction |
| ex_rd | input | RA_W | Destination register of the execute-stage instruction |
| ex_wen | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | RA_W | Destination register of the memory-stage instruction |
| mem_wen | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| wb_rd | input | RA_W | Destination register of the writeback-stage instruction |
| wb_wen | input | 1 | Writeback-stage instruction writes a register |
| fwd_a_sel | output | 2 | Execute operand A source: 0 register file, 1 memory stage, 2 writeback |
| fwd_b_sel | output | 2 | Execute operand B source, same encoding |
| dec_a_sel | output | 2 | Decode operand A source, same encoding |
| dec_b_sel | output | 2 | Decode operand B source, same encoding |
| stall | output | 1 | Hold the PC and the fetch/decode register |
| bubble | output | 1 | Load a no-operation with write enables cleared into execute |
| npc_sel | output | 2 | Next fetch address: 0 sequential, 1 branch target, 2 hold |
| next_pc | output | PC_W | Next fetch address |

## Verification
The bench targets the cases where two stages claim the same register. If memory and writeback both write the source, a design that reverses the priority hands execute a stale value. If register 0 is the source, a design that forgets the zero check bypasses garbage or stalls for nothing. It contrasts a load directly ahead of its consumer with a load one instruction further back: a unit that misjudges the distance either reads unloaded data or wastes a cycle. For branches it covers operands still in execute and loads still in memory, which must wait. An ALU result already in memory must be bypassed into decode without waiting. It also confirms that a stall overrides a taken branch, and that a stray taken flag on a non-branch leaves fetch on its sequential path.

// File: rtl/hazard_unit.sv
module hazard_unit #(
  parameter int RA_W        = 5,
  parameter int PC_W        = 32,
  parameter int INSTR_BYTES = 4
) (
  input  logic [PC_W-1:0] fetch_pc,
  input  logic [RA_W-1:0] dec_rs1,
  input  logic [RA_W-1:0] dec_rs2,
  input  logic            dec_is_branch,
  input  logic            dec_br_taken,
  input  logic [PC_W-1:0] dec_br_target,
  input  logic [RA_W-1:0] ex_rs1,
  input  logic [RA_W-1:0] ex_rs2,
  input  logic [RA_W-1:0] ex_rd,
  input  logic            ex_wen,
  input  logic            ex_is_load,
  input  logic [RA_W-1:0] mem_rd,
  input  logic            mem_wen,
  input  logic            mem_is_load,
  input  logic [RA_W-1:0] wb_rd,
  input  logic            wb_wen,
  output logic [1:0]      fwd_a_sel,
  output logic [1:0]      fwd_b_sel,
  output logic [1:0]      dec_a_sel,
  output logic [1:0]      dec_b_sel,
  output logic            stall,
  output logic            bubble,
  output logic [1:0]      npc_sel,
  output logic [PC_W-1:0] next_pc
);

  localparam logic [1:0] SRC_RF   = 2'd0;
  localparam logic [1:0] SRC_MEM  = 2'd1;
  localparam logic [1:0] SRC_WB   = 2'd2;
  localparam logic [1:0] NPC_SEQ  = 2'd0;
  localparam logic [1:0] NPC_TGT  = 2'd1;
  localparam logic [1:0] NPC_HOLD = 2'd2;
  localparam logic [PC_W-1:0] PC_INC = PC_W'(INSTR_BYTES);

  function automatic logic hit(input logic [RA_W-1:0] src, input logic [RA_W-1:0] dst,
                               input logic wen);
    return wen && (src != '0) && (src == dst);
  endfunction

  function automatic logic [1:0] pick(input logic mem_ok, input logic wb_ok);
    if (mem_ok) return SRC_MEM;
    if (wb_ok)  return SRC_WB;
    return SRC_RF;
  endfunction

  logic mem_alu_wen, mem_ld_wen;
  logic ex_hit_a, ex_hit_b, mld_hit_a, mld_hit_b;
  logic load_use, br_wait, redirect;

  assign mem_alu_wen = mem_wen && !mem_is_load;
  assign mem_ld_wen  = mem_wen && mem_is_load;

  assign fwd_a_sel = pick(hit(ex_rs1, mem_rd, mem_wen), hit(ex_rs1, wb_rd, wb_wen));
  assign fwd_b_sel = pick(hit(ex_rs2, mem_rd, mem_wen), hit(ex_rs2, wb_rd, wb_wen));

  assign dec_a_sel = pick(hit(dec_rs1, mem_rd, mem_alu_wen), hit(dec_rs1, wb_rd, wb_wen));
  assign dec_b_sel = pick(hit(dec_rs2, mem_rd, mem_alu_wen), hit(dec_rs2, wb_rd, wb_wen));

  assign ex_hit_a  = hit(dec_rs1, ex_rd, ex_wen);
  assign ex_hit_b  = hit(dec_rs2, ex_rd, ex_wen);
  assign mld_hit_a = hit(dec_rs1, mem_rd, mem_ld_wen);
  assign mld_hit_b = hit(dec_rs2, mem_rd, mem_ld_wen);

  assign load_use = ex_is_load && (ex_hit_a || ex_hit_b);
  assign br_wait  = dec_is_branch && (ex_hit_a || ex_hit_b || mld_hit_a || mld_hit_b);

  assign stall    = load_use || br_wait;
  assign bubble   = stall;
  assign redirect = dec_is_branch && dec_br_taken;

  assign npc_sel = stall ? NPC_HOLD : (redirect ? NPC_TGT : NPC_SEQ);

  always_comb begin
    case (npc_sel)
      NPC_HOLD: next_pc = fetch_pc;
      NPC_TGT:  next_pc = dec_br_target;
      default:  next_pc = fetch_pc + PC_INC;
    endcase
  end

  always_comb begin
    // R1
    fwd_mem_src_chk: assert (fwd_a_sel != SRC_MEM || (mem_wen && ex_rs1 != '0 && mem_rd == ex_rs1))
      else $error("execute operand A took the memory-stage result without a matching write");
    // R2
    fwd_wb_prio_chk: assert (fwd_b_sel != SRC_WB ||
                             (!(mem_wen && mem_rd == ex_rs2) && wb_wen && wb_rd == ex_rs2 && ex_rs2 != '0))
      else $error("execute operand B took writeback while memory matched or writeback did not");
    // R3
    zero_src_chk: assert (ex_rs1 != '0 || fwd_a_sel == SRC_RF)
      else $error("register 0 was bypassed");
    // R4
    hold_pc_chk: assert (!stall || (next_pc == fetch_pc && bubble))
      else $error("stall without holding the PC and inserting a bubble");
    // R5
    no_spurious_stall_chk: assert (dec_is_branch || (ex_is_load && ex_wen) || !stall)
      else $error("non-branch stalled without a load directly ahead");
    // R10
    taken_redirect_chk: assert (!(dec_is_branch && dec_br_taken && !stall) || next_pc == dec_br_target)
      else $error("resolved taken branch did not redirect fetch");
    // R11
    nonbranch_seq_chk: assert (dec_is_branch || stall || next_pc == fetch_pc + PC_INC)
      else $error("non-branch changed the fetch path");
  end

endmodule

// File: tb/test_hazard_unit.sv
module test_hazard_unit;
  localparam int CLK_PERIOD = 10;
  localparam int RA_W = 5;
  localparam int PC_W = 32;

  typedef struct packed {
    logic [PC_W-1:0] fpc;
    logic [RA_W-1:0] d_rs1, d_rs2;
    logic            d_br, d_tk;
    logic [PC_W-1:0] d_tgt;
    logic [RA_W-1:0] x_rs1, x_rs2, x_rd;
    logic            x_wen, x_ld;
    logic [RA_W-1:0] m_rd;
    logic            m_wen, m_ld;
    logic [RA_W-1:0] w_rd;
    logic            w_wen;
  } stim_t;

  typedef struct {
    logic [1:0]      fa, fb, da, db;
    logic            st;
    logic [1:0]      ns;
    logic [PC_W-1:0] npc;
    string           tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  stim_t s;
  exp_t  q[$];
  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;

  logic [1:0]      fwd_a_sel, fwd_b_sel, dec_a_sel, dec_b_sel, npc_sel;
  logic            stall, bubble;
  logic [PC_W-1:0] next_pc;

  hazard_unit #(.RA_W(RA_W), .PC_W(PC_W), .INSTR_BYTES(4)) i_hazard_unit (
    .fetch_pc(s.fpc), .dec_rs1(s.d_rs1), .dec_rs2(s.d_rs2),
    .dec_is_branch(s.d_br), .dec_br_taken(s.d_tk), .dec_br_target(s.d_tgt),
    .ex_rs1(s.x_rs1), .ex_rs2(s.x_rs2), .ex_rd(s.x_rd), .ex_wen(s.x_wen), .ex_is_load(s.x_ld),
    .mem_rd(s.m_rd), .mem_wen(s.m_wen), .mem_is_load(s.m_ld),
    .wb_rd(s.w_rd), .wb_wen(s.w_wen),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .dec_a_sel(dec_a_sel), .dec_b_sel(dec_b_sel),
    .stall(stall), .bubble(bubble), .npc_sel(npc_sel), .next_pc(next_pc)
  );

  function automatic stim_t nop();
    stim_t n = '0;
    n.fpc   = 32'h100;
    n.d_tgt = 32'h200;
    return n;
  endfunction

  function automatic exp_t mk(input logic [1:0] fa, input logic [1:0] fb, input logic [1:0] da,
                              input logic [1:0] db, input logic st, input logic [1:0] ns,
                              input logic [PC_W-1:0] npc, input string tag);
    exp_t e;
    e.fa = fa; e.fb = fb; e.da = da; e.db = db; e.st = st; e.ns = ns; e.npc = npc; e.tag = tag;
    return e;
  endfunction

  task automatic put(input stim_t st, input exp_t e);
    @(posedge clk);
    s = st;
    q.push_back(e);
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        e = q.pop_front();
        checks++;
        if (fwd_a_sel !== e.fa || fwd_b_sel !== e.fb || dec_a_sel !== e.da || dec_b_sel !== e.db ||
            stall !== e.st || bubble !== e.st || npc_sel !== e.ns || next_pc !== e.npc) begin
          errors++;
          $display("FAIL %s: actual fa=%0d fb=%0d da=%0d db=%0d stall=%0b bubble=%0b ns=%0d npc=%h expected fa=%0d fb=%0d da=%0d db=%0d stall=%0b ns=%0d npc=%h",
                   e.tag, fwd_a_sel, fwd_b_sel, dec_a_sel, dec_b_sel, stall, bubble, npc_sel, next_pc,
                   e.fa, e.fb, e.da, e.db, e.st, e.ns, e.npc);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    stim_t st;
    s = nop();
    s.fpc = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    st = nop(); st.fpc = '0;
    put(st, mk(0, 0, 0, 0, 0, 0, 32'h4, "reset idle"));

    st = nop(); st.x_rs1 = 3; st.m_rd = 3; st.m_wen = 1; st.w_rd = 3; st.w_wen = 1;
    put(st, mk(1, 0, 0, 0, 0, 0, 32'h104, "R1 memory beats writeback"));

    st = nop(); st.x_rs1 = 7; st.x_rs2 = 5; st.w_rd = 5; st.w_wen = 1; st.m_rd = 6; st.m_wen = 1;
    put(st, mk(0, 2, 0, 0, 0, 0, 32'h104, "R2 writeback only"));

    st = nop(); st.x_rs1 = 4; st.m_rd = 4; st.m_wen = 0; st.x_rs2 = 9; st.w_rd = 9; st.w_wen = 0;
    put(st, mk(0, 0, 0, 0, 0, 0, 32'h104, "R2 write enables clear"));

    st = nop(); st.x_rs1 = 0; st.m_rd = 0; st.m_wen = 1; st.w_rd = 0; st.w_wen = 1;
    st.d_rs1 = 0; st.x_rd = 0; st.x_wen = 1; st.x_ld = 1;
    put(st, mk(0, 0, 0, 0, 0, 0, 32'h104, "R3 register 0 non-branch"));

    st = nop(); st.d_br = 1; st.d_tk = 1; st.d_rs1 = 0; st.x_rd = 0; st.x_wen = 1;
    st.m_rd = 0; st.m_wen = 1; st.m_ld = 1;
    put(st, mk(0, 0, 0, 0, 0, 1, 32'h200, "R3 register 0 branch"));

    st = nop(); st.x_ld = 1; st.x_wen = 1; st.x_rd = 8; st.d_rs2 = 8;
    put(st, mk(0, 0, 0, 0, 1, 2, 32'h100, "R4 load-use stall"));

    st = nop(); st.m_ld = 1; st.m_wen = 1; st.m_rd = 8; st.d_rs1 = 8; st.x_rd = 9; st.x_wen = 1;
    put(st, mk(0, 0, 0, 0, 0, 0, 32'h104, "R5 load with gap"));

    st = nop(); st.d_rs1 = 10; st.w_rd = 10; st.w_wen = 1; st.d_rs2 = 11; st.m_rd = 11; st.m_wen = 1;
    put(st, mk(0, 0, 2, 1, 0, 0, 32'h104, "R6 decode bypass sources"));

    st = nop(); st.d_rs1 = 12; st.m_rd = 12; st.m_wen = 1; st.w_rd = 12; st.w_wen = 1;
    put(st, mk(0, 0, 1, 0, 0, 0, 32'h104, "R6 decode priority"));

    st = nop(); st.d_br = 1; st.d_tk = 1; st.d_rs1 = 13; st.x_rd = 13; st.x_wen = 1;
    put(st, mk(0, 0, 0, 0, 1, 2, 32'h100, "R7 branch waits on execute"));

    st = nop(); st.d_rs1 = 15; st.x_rd = 15; st.x_wen = 1; st.x_rs1 = 15; st.m_rd = 15; st.m_wen = 1;
    put(st, mk(1, 0, 1, 0, 0, 0, 32'h104, "R7 non-branch ALU no stall"));

    st = nop(); st.d_br = 1; st.d_rs2 = 14; st.m_rd = 14; st.m_wen = 1; st.m_ld = 1;
    put(st, mk(0, 0, 0, 0, 1, 2, 32'h100, "R8 branch waits on load"));

    st = nop(); st.d_br = 1; st.d_tk = 1; st.d_rs2 = 14; st.m_rd = 14; st.m_wen = 1;
    put(st, mk(0, 0, 0, 1, 0, 1, 32'h200, "R8 branch bypass from memory"));

    st = nop(); st.d_br = 1; st.d_tk = 0; st.d_rs1 = 2;
    put(st, mk(0, 0, 0, 0, 0, 0, 32'h104, "R9 not taken"));

    st = nop(); st.d_br = 1; st.d_tk = 1; st.fpc = 32'h3F0; st.d_tgt = 32'h40;
    put(st, mk(0, 0, 0, 0, 0, 1, 32'h40, "R10 taken redirect"));

    st = nop(); st.d_tk = 1; st.d_rs1 = 5;
    put(st, mk(0, 0, 0, 0, 0, 0, 32'h104, "R11 taken flag ignored"));

    wait (q.size() == 0);
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule